// File: doc/BRIEF.md
# Reorder-Buffer Insertion Skid Buffer

This block sits between register renaming and reorder-buffer (ROB) insertion. Each cycle rename offers a group of up to `W` instructions. Each slot carries a valid bit, a squashed bit, a thread id, a program counter and a sequence number. The block forwards up to `W` instructions per cycle to the ROB write port.

Instructions that do not fit in this cycle's insertion budget are parked in an internal ring buffer, and so is the whole group when commit is not processing. Parked instructions always go ahead of fresh rename traffic, so program order is kept. Squashed instructions are dropped: they are never stored and never reach the ROB.

The ring buffer has `DEPTH` entries, with `DEPTH` at least `2*W` and a power of two. A ready signal tells rename when a full group may no longer fit. A flush empties the buffer in one cycle.

Top module: `rob_skid_buffer`

## Requirements
- R1: During and right after a synchronous reset, `ins_valid` is all zero, `rename_ready` is 1 and no parked entry survives. A later cycle with commit active and no input therefore yields no output.
- R2: Outputs are registered. A group presented before clock edge k appears on the `ins_*` ports after edge k, and not before it.
- R3: Parked entries are emitted before any instruction of the current rename group, oldest first. Rename instructions follow in their slot order.
- R4: With commit active and no flush, the number of instructions taken in a cycle is min(`W`, incoming valid count + parked count). If `W` or more are parked, `W` valid outputs follow.
- R5: Incoming instructions beyond that budget are parked in slot order and emitted in a later cycle.
- R6: An instruction whose squashed bit is set never appears on the outputs and is never parked.
- R7: When `commit_active` is 0, nothing is emitted in the next cycle. Every non-squashed valid incoming instruction is parked.
- R8: Output slots are packed contiguously from slot 0. `ins_valid` bit i is slot i, and bit i is set only if bits 0..i-1 are set.
- R9: `rename_ready` is 1 exactly when at least `W` ring entries are free. Occupancy never exceeds `DEPTH`.
- R10: A `flush` cycle empties the ring and discards that cycle's incoming group. The next cycle shows no valid output.
- R11: Input slots with the valid bit clear are skipped. Gaps in the incoming group do not change the order of the remaining instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the ring and drop the current group |
| commit_active | input | 1 | Commit is processing instructions this cycle |
| ren_valid | input | W | Per-slot valid from rename (bit i = slot i) |
| ren_squash | input | W | Per-slot squashed marker |
| ren_tid | input | W*TID_W | Thread id per slot, slot i at bits [i*TID_W +: TID_W] |
| ren_pc | input | W*PC_W | Program counter per slot |
| ren_seq | input | W*SEQ_W | Sequence number per slot |
| rename_ready | output | 1 | At least W free ring entries |
| ins_valid | output | W | Registered per-slot valid toward the ROB |
| ins_tid | output | W*TID_W | Registered thread id per output slot |
| ins_pc | output | W*PC_W | Registered program counter per output slot |
| ins_seq | output | W*SEQ_W | Registered sequence number per output slot |

## Verification
On every cycle, the assertions check several properties. Output packing must be contiguous, and ring occupancy must stay within depth. A stalled-commit or flush cycle must be followed by empty outputs, a flush must also leave the ring empty, and a ring holding at least `W` entries must drain a full group. Ordering across cycles can only be shown by the scenarios. These cover parked-before-fresh priority, the exact budget split, squash filtering within a mixed group, and the sequence numbers that leave after a stall or overflow. The scenarios also check the deassertion of `rename_ready` at full occupancy and the one-cycle output latency.

// File: rtl/skid_pkg.sv
package skid_pkg;
  localparam int TID_W = 2;
  localparam int PC_W  = 32;
  localparam int SEQ_W = 16;

  typedef struct packed {
    logic             squash;
    logic [TID_W-1:0] tid;
    logic [PC_W-1:0]  pc;
    logic [SEQ_W-1:0] seq;
  } entry_t;
endpackage

// File: rtl/skid_compact.sv
// Packs the kept entries of a W-wide group toward slot 0, preserving order.
module skid_compact
  import skid_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]               keep_i,
  input  entry_t                     data_i [W],
  output entry_t                     data_o [W],
  output logic [W-1:0]               valid_o,
  output logic [$clog2(W+1)-1:0]     cnt_o
);
  localparam int CNT_W = $clog2(W+1);

  always_comb begin
    int pos;
    pos = 0;
    valid_o = '0;
    for (int o = 0; o < W; o++) data_o[o] = '0;
    for (int i = 0; i < W; i++) begin
      if (keep_i[i]) begin
        for (int o = 0; o < W; o++) begin
          if (o == pos) begin
            data_o[o]  = data_i[i];
            valid_o[o] = 1'b1;
          end
        end
        pos = pos + 1;
      end
    end
    cnt_o = CNT_W'(pos);
  end
endmodule

// File: rtl/skid_fifo.sv
// Ring buffer with up to W pushes and W pops per cycle; head window read out.
module skid_fifo
  import skid_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic [$clog2(W+1)-1:0]       push_cnt,
  input  entry_t                       push_data [W],
  input  logic [$clog2(W+1)-1:0]       pop_cnt,
  output entry_t                       head_data [W],
  output logic [$clog2(DEPTH+1)-1:0]   occ
);
  localparam int CNT_W = $clog2(W+1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int OCC_W = $clog2(DEPTH+1);

  entry_t            mem [DEPTH];
  logic [IDX_W-1:0]  head_q;
  logic [IDX_W-1:0]  tail_q;
  logic [OCC_W-1:0]  occ_q;

  // Storage: no reset, written only at the tail window.
  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      if (!flush && (CNT_W'(i) < push_cnt))
        mem[tail_q + IDX_W'(i)] <= push_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= head_q + IDX_W'(pop_cnt);
      tail_q <= tail_q + IDX_W'(push_cnt);
      occ_q  <= occ_q - OCC_W'(pop_cnt) + OCC_W'(push_cnt);
    end
  end

  for (genvar s = 0; s < W; s++) begin : g_head
    assign head_data[s] = mem[head_q + IDX_W'(s)];
  end

  assign occ = occ_q;
endmodule

// File: rtl/rob_skid_buffer.sv
module rob_skid_buffer
  import skid_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 2 * W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               commit_active,
  input  logic [W-1:0]       ren_valid,
  input  logic [W-1:0]       ren_squash,
  input  logic [W*TID_W-1:0] ren_tid,
  input  logic [W*PC_W-1:0]  ren_pc,
  input  logic [W*SEQ_W-1:0] ren_seq,
  output logic               rename_ready,
  output logic [W-1:0]       ins_valid,
  output logic [W*TID_W-1:0] ins_tid,
  output logic [W*PC_W-1:0]  ins_pc,
  output logic [W*SEQ_W-1:0] ins_seq
);
  localparam int CNT_W = $clog2(W+1);
  localparam int OCC_W = $clog2(DEPTH+1);
  localparam int SUM_W = OCC_W + 1;

  entry_t             raw_ent   [W];
  entry_t             in_pk     [W];
  logic [W-1:0]       in_pk_vld;
  logic [CNT_W-1:0]   in_cnt;

  entry_t             head_ent  [W];
  logic [OCC_W-1:0]   skid_occ;

  entry_t             cand      [W];
  logic [W-1:0]       cand_keep;
  entry_t             out_pk    [W];
  logic [W-1:0]       out_pk_vld;
  logic [CNT_W-1:0]   out_cnt;

  logic [W-1:0]       push_keep;
  entry_t             push_ent  [W];
  logic [W-1:0]       push_vld;
  logic [CNT_W-1:0]   push_cnt;

  logic [CNT_W-1:0]   take_skid;
  logic [CNT_W-1:0]   take_ren;
  logic [CNT_W-1:0]   take_all;
  logic [SUM_W-1:0]   avail;
  logic               taking;

  entry_t             out_q     [W];
  logic [W-1:0]       out_vld_q;

  // Unpack the incoming group into entries.
  for (genvar g = 0; g < W; g++) begin : g_unpack
    assign raw_ent[g].squash = ren_squash[g];
    assign raw_ent[g].tid    = ren_tid[g*TID_W +: TID_W];
    assign raw_ent[g].pc     = ren_pc[g*PC_W +: PC_W];
    assign raw_ent[g].seq    = ren_seq[g*SEQ_W +: SEQ_W];
  end

  // Close gaps between valid input slots.
  skid_compact #(.W(W)) u_in_pack (
    .keep_i  (ren_valid),
    .data_i  (raw_ent),
    .data_o  (in_pk),
    .valid_o (in_pk_vld),
    .cnt_o   (in_cnt)
  );

  // Insertion budget split between parked and fresh instructions.
  assign taking = commit_active && !flush;
  assign avail  = SUM_W'(skid_occ) + SUM_W'(in_cnt);

  always_comb begin
    if (!taking) begin
      take_skid = '0;
      take_all  = '0;
    end else begin
      take_skid = (skid_occ > OCC_W'(W)) ? CNT_W'(W) : CNT_W'(skid_occ);
      take_all  = (avail > SUM_W'(W)) ? CNT_W'(W) : CNT_W'(avail);
    end
    take_ren = take_all - take_skid;
  end

  // Slot candidates: parked head first, then fresh packed entries.
  always_comb begin
    for (int s = 0; s < W; s++) begin
      int idx;
      idx          = s - int'(take_skid);
      cand[s]      = '0;
      cand_keep[s] = 1'b0;
      if (CNT_W'(s) < take_skid) begin
        cand[s]      = head_ent[s];
        cand_keep[s] = 1'b1;
      end else if (CNT_W'(s) < take_all) begin
        for (int j = 0; j < W; j++) begin
          if (j == idx) begin
            cand[s]      = in_pk[j];
            cand_keep[s] = !in_pk[j].squash;
          end
        end
      end
    end
  end

  skid_compact #(.W(W)) u_out_pack (
    .keep_i  (cand_keep),
    .data_i  (cand),
    .data_o  (out_pk),
    .valid_o (out_pk_vld),
    .cnt_o   (out_cnt)
  );

  // Leftover fresh instructions go to the ring; squashed ones are dropped.
  always_comb begin
    for (int j = 0; j < W; j++) begin
      push_keep[j] = in_pk_vld[j] && !flush && !in_pk[j].squash &&
                     (CNT_W'(j) >= take_ren);
    end
  end

  skid_compact #(.W(W)) u_push_pack (
    .keep_i  (push_keep),
    .data_i  (in_pk),
    .data_o  (push_ent),
    .valid_o (push_vld),
    .cnt_o   (push_cnt)
  );

  skid_fifo #(.W(W), .DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push_cnt  (push_cnt),
    .push_data (push_ent),
    .pop_cnt   (take_skid),
    .head_data (head_ent),
    .occ       (skid_occ)
  );

  // Registered output stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld_q <= '0;
      for (int s = 0; s < W; s++) out_q[s] <= '0;
    end else begin
      out_vld_q <= out_pk_vld;
      for (int s = 0; s < W; s++) out_q[s] <= out_pk[s];
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_pack_out
    assign ins_tid[g*TID_W +: TID_W] = out_q[g].tid;
    assign ins_pc[g*PC_W +: PC_W]    = out_q[g].pc;
    assign ins_seq[g*SEQ_W +: SEQ_W] = out_q[g].seq;
  end

  assign ins_valid    = out_vld_q;
  assign rename_ready = (SUM_W'(skid_occ) + SUM_W'(W)) <= SUM_W'(DEPTH);
endmodule

// File: rtl/rob_skid_buffer_chk.sv
module rob_skid_buffer_chk #(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       flush,
  input logic                       commit_active,
  input logic [W-1:0]               ren_valid,
  input logic [W-1:0]               ins_valid,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= ($clog2(DEPTH+1))'(DEPTH));

  // R8
  packed_slots_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_valid & (ins_valid + W'(1))) == '0);

  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_active |=> ins_valid == '0);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ins_valid == '0) && (occ == '0));

  // R4
  full_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_active && !flush && (occ >= ($clog2(DEPTH+1))'(W)))
      |=> $countones(ins_valid) == W);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_active && !flush && ren_valid == '0 && occ == '0)
      |=> ins_valid == '0);
endmodule

bind rob_skid_buffer rob_skid_buffer_chk #(.W(W), .DEPTH(DEPTH)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .flush         (flush),
  .commit_active (commit_active),
  .ren_valid     (ren_valid),
  .ins_valid     (ins_valid),
  .occ           (skid_occ)
);

// File: tb/rob_skid_buffer_tb_top.sv
`timescale 1ns/1ps
module rob_skid_buffer_tb_top;
  import skid_pkg::*;

  localparam int W     = 4;
  localparam int DEPTH = 8;
  localparam int NV    = 11;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               flush = 1'b0;
  logic               commit_active = 1'b0;
  logic [W-1:0]       ren_valid = '0;
  logic [W-1:0]       ren_squash = '0;
  logic [W*TID_W-1:0] ren_tid = '0;
  logic [W*PC_W-1:0]  ren_pc = '0;
  logic [W*SEQ_W-1:0] ren_seq = '0;
  logic               rename_ready;
  logic [W-1:0]       ins_valid;
  logic [W*TID_W-1:0] ins_tid;
  logic [W*PC_W-1:0]  ins_pc;
  logic [W*SEQ_W-1:0] ins_seq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rob_skid_buffer #(.W(W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .flush(flush), .commit_active(commit_active),
    .ren_valid(ren_valid), .ren_squash(ren_squash), .ren_tid(ren_tid),
    .ren_pc(ren_pc), .ren_seq(ren_seq), .rename_ready(rename_ready),
    .ins_valid(ins_valid), .ins_tid(ins_tid), .ins_pc(ins_pc), .ins_seq(ins_seq)
  );

  // Stimulus/expectation table. Step k uses seq 16*k+slot, tid=slot, pc=4*seq.
  localparam logic       T_ACT [NV] = '{1, 0, 1, 1, 1, 0, 0, 1, 1, 1, 1};
  localparam logic [3:0] T_VLD [NV] = '{4'b1111, 4'b1111, 4'b0011, 4'b1111, 4'b1010,
                                        4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 4'b1111};
  localparam logic [3:0] T_SQ  [NV] = '{4'b0000, 4'b0100, 4'b0000, 4'b0001, 4'b0000,
                                        4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b1000};
  localparam int         T_CNT [NV] = '{4, 0, 4, 3, 3, 0, 0, 4, 4, 0, 3};
  localparam logic       T_RDY [NV] = '{1, 1, 1, 1, 1, 1, 0, 1, 1, 1, 1};
  localparam int         T_E0  [NV] = '{16, 0, 32, 49, 67, 0, 0, 96, 112, 0, 176};
  localparam int         T_E1  [NV] = '{17, 0, 33, 65, 81, 0, 0, 97, 113, 0, 177};
  localparam int         T_E2  [NV] = '{18, 0, 35, 66, 83, 0, 0, 98, 114, 0, 178};
  localparam int         T_E3  [NV] = '{19, 0, 48, 0, 0, 0, 0, 99, 115, 0, 0};

  function automatic string step_req(input int k);
    case (k)
      1:  return "R4";
      2:  return "R7/R6";
      3:  return "R3/R5";
      4:  return "R6/R5";
      5:  return "R11";
      6:  return "R7";
      7:  return "R9";
      8:  return "R3";
      9:  return "R4";
      10: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit act, input logic [3:0] v, input logic [3:0] sq, input int k);
    commit_active = act;
    ren_valid     = v;
    ren_squash    = sq;
    for (int i = 0; i < W; i++) begin
      ren_tid[i*TID_W +: TID_W] = TID_W'(i);
      ren_seq[i*SEQ_W +: SEQ_W] = SEQ_W'(16*k + i);
      ren_pc[i*PC_W +: PC_W]    = PC_W'(4*(16*k + i));
    end
  endtask

  task automatic check_out(input int cnt, input int e0, input int e1, input int e2,
                           input int e3, input bit rdy, input string req);
    int e [W];
    logic [W-1:0] mask;
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    mask = W'((1 << cnt) - 1);
    check(ins_valid == mask, req, "valid mask", ins_valid, mask);
    check(rename_ready == rdy, "R9", "rename_ready", rename_ready, rdy);
    for (int s = 0; s < W; s++) begin
      if (s < cnt) begin
        check(ins_seq[s*SEQ_W +: SEQ_W] == SEQ_W'(e[s]), req, $sformatf("seq slot %0d", s),
              ins_seq[s*SEQ_W +: SEQ_W], e[s]);
        check(ins_pc[s*PC_W +: PC_W] == PC_W'(4*e[s]), req, $sformatf("pc slot %0d", s),
              ins_pc[s*PC_W +: PC_W], 4*e[s]);
        check(ins_tid[s*TID_W +: TID_W] == TID_W'(e[s]), req, $sformatf("tid slot %0d", s),
              ins_tid[s*TID_W +: TID_W], e[s] % 4);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check_out(0, 0, 0, 0, 0, 1'b1, "R1");
    rst = 1'b0;

    // Table walk: drive at negedge, result visible after the next edge.
    for (int k = 0; k < NV; k++) begin
      drive(T_ACT[k], T_VLD[k], T_SQ[k], k + 1);
      @(negedge clk);
      check_out(T_CNT[k], T_E0[k], T_E1[k], T_E2[k], T_E3[k], T_RDY[k], step_req(k + 1));
    end

    // R10: park a group, then flush with a fresh group present.
    drive(1'b0, 4'b1111, 4'b0000, 12);
    @(negedge clk);
    check_out(0, 0, 0, 0, 0, 1'b1, "R7");
    flush = 1'b1;
    drive(1'b1, 4'b1111, 4'b0000, 13);
    @(negedge clk);
    check_out(0, 0, 0, 0, 0, 1'b1, "R10");
    flush = 1'b0;
    drive(1'b1, 4'b0000, 4'b0000, 0);
    @(negedge clk);
    check_out(0, 0, 0, 0, 0, 1'b1, "R10");

    // R1: reset in mid-run discards parked entries.
    drive(1'b0, 4'b1111, 4'b0000, 14);
    @(negedge clk);
    rst = 1'b1;
    drive(1'b1, 4'b0000, 4'b0000, 0);
    @(negedge clk);
    check_out(0, 0, 0, 0, 0, 1'b1, "R1");
    rst = 1'b0;
    @(negedge clk);
    check_out(0, 0, 0, 0, 0, 1'b1, "R1");

    // R2: output changes only after the clock edge.
    drive(1'b1, 4'b1111, 4'b0000, 15);
    #1;
    check(ins_valid == '0, "R2", "valid before edge", ins_valid, 0);
    @(negedge clk);
    check_out(4, 240, 241, 242, 243, 1'b1, "R2");

    drive(1'b0, 4'b0000, 4'b0000, 0);
    @(negedge clk);
    finish_run();
  end
endmodule